// File: doc/BRIEF.md
# Phase comparator with programmable drive polarity and lock detect

The block measures the timing error between a comparison clock and a divided-down oscillator clock, both sampled by a fast system clock. It uses a two-state phase-frequency detector. A rising edge on the comparison clock arms the "up" state and a rising edge on the oscillator clock arms the "down" state. Whenever both would be armed at once, the pair is cleared. Each pulse therefore lasts as many system-clock cycles as the two rising edges are apart.

The up and down pulses pass through a resolution filter. A pulse shorter than `MIN_WIDTH` system cycles is removed. A longer pulse comes out with its width intact, delayed by `MIN_WIDTH-1` cycles. The filtered pulses feed a single drive output with an enable. While the enable is low, the drive stands for the high-impedance state. A polarity input chooses which edge order drives the line high. A separate active-low lock output drops for the unfiltered phase error on every comparison.

Top module: `phaseComparator`

## Requirements
- R1: While the synchronous active-high reset is sampled high, upPulse, downPulse, driveEn and driveOut are 0 and lockN is 1.
- R2: A rising edge of refClk arms the up state and a rising edge of vcoClk arms the down state. When both would be armed, both clear. Edges sampled in the same system cycle produce no pulse.
- R3: When refClk leads vcoClk by D system cycles and D >= MIN_WIDTH, upPulse is high for exactly D cycles and downPulse stays low. With the roles swapped, downPulse is high for D cycles and upPulse stays low.
- R4: A phase error of fewer than MIN_WIDTH cycles produces no upPulse, downPulse or driveEn activity.
- R5: With polarity = 1, an up pulse gives driveEn = 1 with driveOut = 1, and a down pulse gives driveEn = 1 with driveOut = 0.
- R6: With polarity = 0, an up pulse gives driveOut = 0 and a down pulse gives driveOut = 1, each with driveEn = 1.
- R7: driveEn is 1 exactly in the cycles where upPulse or downPulse is 1. While driveEn is 0, driveOut is 0, which is the high-impedance condition.
- R8: lockN is 0 for exactly D cycles per comparison, including errors below MIN_WIDTH, and stays 1 when the edges coincide.
- R9: A second refClk rising edge before any vcoClk rising edge keeps the up state armed. The up pulse then spans from the first refClk edge to the vcoClk edge.
- R10: upPulse and downPulse are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| refClk | input | 1 | Comparison clock |
| vcoClk | input | 1 | Divided oscillator clock |
| polarity | input | 1 | Drive polarity select (1: reference lead drives high) |
| upPulse | output | 1 | Filtered reference-leads pulse |
| downPulse | output | 1 | Filtered oscillator-leads pulse |
| driveOut | output | 1 | Drive level, valid while driveEn is 1 |
| driveEn | output | 1 | Drive enable; 0 means high impedance |
| lockN | output | 1 | Active-low phase-error pulse |

## Verification
The bench builds the block with MIN_WIDTH = 3 and SYNC_STAGES = 2. With these values, errors of one and two cycles fall inside the dead zone and three cycles sits exactly on the threshold. Within a 40-cycle comparison period, errors of 5, 12 and 20 cycles test the exact width carried through the filter delay. Both polarities are run against both lead directions. A double reference edge covers frequency detection.

// File: rtl/pfdPkg.sv
package pfdPkg;
  typedef struct packed {
    logic rawUp;
    logic rawDn;
    logic clrBoth;
  } pfdStrobe_t;
endpackage

// File: rtl/edgeSampler.sv
module edgeSampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sigIn,
  output logic riseOut
);
  logic [STAGES-1:0] chain;
  logic              lastQ;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= sigIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lastQ <= 1'b0;
    else     lastQ <= chain[STAGES-1];
  end

  assign riseOut = chain[STAGES-1] & ~lastQ;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    riseOut |=> !riseOut);
endmodule

// File: rtl/pfdCtrl.sv
module pfdCtrl
  import pfdPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       refRise,
  input  logic       vcoRise,
  output pfdStrobe_t strobes
);
  logic upQ, dnQ;
  logic nextUp, nextDn, bothArmed;

  always_comb begin
    nextUp    = upQ | refRise;
    nextDn    = dnQ | vcoRise;
    bothArmed = nextUp & nextDn;
  end

  always_ff @(posedge clk) begin
    if (rst || bothArmed) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= nextUp;
      dnQ <= nextDn;
    end
  end

  assign strobes.rawUp   = upQ;
  assign strobes.rawDn   = dnQ;
  assign strobes.clrBoth = bothArmed;

  // R2
  up_set_by_ref_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(upQ) |-> $past(refRise));
  // R2
  dn_set_by_vco_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dnQ) |-> $past(vcoRise));
endmodule

// File: rtl/pulseQualifier.sv
module pulseQualifier #(
  parameter int MIN_WIDTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic pulseOut
);
  localparam int CW = (MIN_WIDTH < 2) ? 1 : $clog2(MIN_WIDTH + 1);
  localparam logic [CW-1:0] THRESH = CW'(MIN_WIDTH - 1);
  localparam logic [CW-1:0] SATVAL = CW'(MIN_WIDTH);

  logic [CW-1:0] runCnt;
  logic [CW-1:0] holdCnt;
  logic          qualified;

  assign qualified = rawIn && (runCnt >= THRESH);

  always_ff @(posedge clk) begin
    if (rst || !rawIn)          runCnt <= '0;
    else if (runCnt != SATVAL)  runCnt <= runCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 holdCnt <= '0;
    else if (qualified)      holdCnt <= THRESH;
    else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
  end

  assign pulseOut = qualified || (holdCnt != '0);

  // R4
  start_needs_raw_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulseOut) |-> rawIn);
endmodule

// File: rtl/pfdDatapath.sv
module pfdDatapath
  import pfdPkg::*;
#(
  parameter int MIN_WIDTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  pfdStrobe_t strobes,
  input  logic       polarity,
  output logic       upOut,
  output logic       dnOut,
  output logic       driveOut,
  output logic       driveEn,
  output logic       lockN
);
  localparam int NDIR = 2;
  logic [NDIR-1:0] rawVec;
  logic [NDIR-1:0] filtVec;

  assign rawVec = {strobes.rawDn, strobes.rawUp};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    pulseQualifier #(.MIN_WIDTH(MIN_WIDTH)) u_qual (
      .clk     (clk),
      .rst     (rst),
      .rawIn   (rawVec[d]),
      .pulseOut(filtVec[d])
    );
  end

  always_comb begin
    upOut   = filtVec[0];
    dnOut   = filtVec[1];
    driveEn = upOut | dnOut;
    if (!driveEn)      driveOut = 1'b0;
    else if (polarity) driveOut = upOut;
    else               driveOut = dnOut;
    lockN   = ~(strobes.rawUp | strobes.rawDn);
  end

  // R10
  no_both_dirs_chk: assert property (@(posedge clk) disable iff (rst)
    !(upOut && dnOut));
  // R5
  up_level_chk: assert property (@(posedge clk) disable iff (rst)
    upOut |-> (driveEn && (driveOut == polarity)));
  // R6
  dn_level_chk: assert property (@(posedge clk) disable iff (rst)
    dnOut |-> (driveEn && (driveOut == !polarity)));
  // R8
  lock_while_raw_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.clrBoth |=> lockN);
endmodule

// File: rtl/phaseComparator.sv
module phaseComparator
  import pfdPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WIDTH   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic refClk,
  input  logic vcoClk,
  input  logic polarity,
  output logic upPulse,
  output logic downPulse,
  output logic driveOut,
  output logic driveEn,
  output logic lockN
);
  logic       refRise, vcoRise;
  pfdStrobe_t strobes;

  edgeSampler #(.STAGES(SYNC_STAGES)) u_refSamp (
    .clk(clk), .rst(rst), .sigIn(refClk), .riseOut(refRise)
  );
  edgeSampler #(.STAGES(SYNC_STAGES)) u_vcoSamp (
    .clk(clk), .rst(rst), .sigIn(vcoClk), .riseOut(vcoRise)
  );

  pfdCtrl u_ctrl (
    .clk(clk), .rst(rst), .refRise(refRise), .vcoRise(vcoRise),
    .strobes(strobes)
  );

  pfdDatapath #(.MIN_WIDTH(MIN_WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .polarity (polarity),
    .upOut    (upPulse),
    .dnOut    (downPulse),
    .driveOut (driveOut),
    .driveEn  (driveEn),
    .lockN    (lockN)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!upPulse && !downPulse && !driveEn && lockN));
  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !driveEn |-> !driveOut);
endmodule

// File: tb/phaseComparator_bench.sv
module phaseComparator_bench;
  localparam int MINW   = 3;
  localparam int PERIOD = 40;
  localparam int NPER   = 3;
  localparam int NVEC   = 12;
  localparam int VEC_D [NVEC] = '{5, -5, 5, -5, 0, 2, -2, 3, -3, 12, 1, -20};
  localparam bit VEC_P [NVEC] = '{1, 1, 0, 0, 1, 1, 1, 1, 0, 1, 0, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refClk = 1'b0, vcoClk = 1'b0, polarity = 1'b1;
  logic upPulse, downPulse, driveOut, driveEn, lockN;

  int checks = 0, errors = 0;
  int upCnt, dnCnt, enCnt, hiCnt, lockCnt, bothCnt, strayCnt;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phaseComparator #(.SYNC_STAGES(2), .MIN_WIDTH(MINW)) u_phaseComparator (
    .clk(clk), .rst(rst), .refClk(refClk), .vcoClk(vcoClk),
    .polarity(polarity), .upPulse(upPulse), .downPulse(downPulse),
    .driveOut(driveOut), .driveEn(driveEn), .lockN(lockN)
  );

  always @(negedge clk) begin
    upCnt    += int'(upPulse);
    dnCnt    += int'(downPulse);
    enCnt    += int'(driveEn);
    hiCnt    += int'(driveEn && driveOut);
    lockCnt  += int'(!lockN);
    bothCnt  += int'(upPulse && downPulse);
    strayCnt += int'(!driveEn && driveOut);
  end

  task automatic clearCounts();
    upCnt = 0; dnCnt = 0; enCnt = 0; hiCnt = 0;
    lockCnt = 0; bothCnt = 0; strayCnt = 0;
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic runPeriod(int refAt, int vcoAt);
    for (int c = 0; c < PERIOD; c++) begin
      refClk = (c >= refAt) && (c < refAt + 8);
      vcoClk = (c >= vcoAt) && (c < vcoAt + 8);
      @(negedge clk);
    end
    refClk = 1'b0; vcoClk = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, mag, expUp, expDn;
    clearCounts();
    idle(4);
    // R1: idle outputs while in reset
    check("R1", "upPulse", int'(upPulse), 0);
    check("R1", "downPulse", int'(downPulse), 0);
    check("R1", "driveEn", int'(driveEn), 0);
    check("R1", "driveOut", int'(driveOut), 0);
    check("R1", "lockN", int'(lockN), 1);
    rst = 1'b0;
    idle(4);

    for (int v = 0; v < NVEC; v++) begin
      d = VEC_D[v];
      mag = (d < 0) ? -d : d;
      polarity = VEC_P[v];
      idle(2);
      clearCounts();
      for (int p = 0; p < NPER; p++)
        runPeriod((d >= 0) ? 0 : -d, (d >= 0) ? d : 0);
      idle(12);
      expUp = (d > 0 && mag >= MINW) ? NPER * mag : 0;
      expDn = (d < 0 && mag >= MINW) ? NPER * mag : 0;
      if (d == 0) begin
        check("R2", "coincident up", upCnt, 0);
        check("R2", "coincident down", dnCnt, 0);
      end else if (mag < MINW) begin
        check("R4", "deadzone up", upCnt, 0);
        check("R4", "deadzone down", dnCnt, 0);
      end else begin
        check("R3", "up width", upCnt, expUp);
        check("R3", "down width", dnCnt, expDn);
      end
      if (VEC_P[v]) check("R5", "drive high cycles", hiCnt, expUp);
      else          check("R6", "drive high cycles", hiCnt, expDn);
      check("R7", "enable cycles", enCnt, expUp + expDn);
      check("R7", "drive while disabled", strayCnt, 0);
      check("R8", "lock low cycles", lockCnt, NPER * mag);
      check("R10", "overlap cycles", bothCnt, 0);
    end

    // R9: two reference edges before one oscillator edge
    polarity = 1'b1;
    clearCounts();
    for (int c = 0; c < PERIOD; c++) begin
      refClk = (c < 5) || (c >= 10 && c < 15);
      vcoClk = (c >= 25) && (c < 30);
      @(negedge clk);
    end
    refClk = 1'b0; vcoClk = 1'b0;
    idle(12);
    check("R9", "stretched up width", upCnt, 25);
    check("R9", "down width", dnCnt, 0);
    check("R9", "lock low cycles", lockCnt, 25);

    // R1: reset in the middle of an armed pulse
    clearCounts();
    refClk = 1'b1;
    idle(5);
    rst = 1'b1;
    refClk = 1'b0;
    idle(3);
    check("R1", "lockN during reset", int'(lockN), 1);
    check("R1", "driveEn during reset", int'(driveEn), 0);
    rst = 1'b0;
    clearCounts();
    idle(10);
    check("R1", "enable after reset", enCnt, 0);
    check("R1", "lock low after reset", lockCnt, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule